// File: doc/BRIEF.md
# Tiled Unsigned Multiply-Add Array

This block is a purely combinational unsigned multiplier that also folds two extra addends into the same pass, producing `x*y + k + m`. The multiplicand `x` and the addend `k` share one width. The multiplier `y` and the addend `m` share the other. The result is exactly as wide as the two operand widths added together. Because `(2^a-1)(2^b-1) + (2^a-1) + (2^b-1) = 2^(a+b)-1`, the result can never overflow, and no separate adder stage follows the array.

The array is a grid of identical 2x2-bit multiply-add slices, and each slice is a grid of four one-bit cells. Every cell adds the AND of its two operand bits to two incoming bits. The slices connect only to their neighbours, through cascade pins, with no glue logic between them. The external `k` bits enter along the top edge and the external `m` bits enter along the left edge. An odd operand width is rounded up to the next even value, and the extra operand bits are tied to zero.

A slice used on its own, with its row carry wired back into its third `m` input, forms a complete 2x2 multiplier with a 4-bit result.

Top module: `tile_mul_add`

## Requirements
- R1: For every input combination, `sum_o` equals `x_i*y_i + k_i + m_i`, with all values taken as unsigned binary numbers.
- R2: A slice satisfies `X*Y + K + M0 + 2*M1 + 4*M2 = S0 + 2*S1 + 4*S2 + 8*C1 + 4*C0`. Here `X = x_i[1:0]`, `Y = y_i[1:0]`, `K = k_i[1:0]`, `M0 = m_i[0]`, `M1 = m_i[1]`, `M2 = m2_i`, `S0..S2 = s0_o..s2_o`, `C1 = c1_o` and `C0 = c0_o`.
- R3: A slice with `c0_o` wired to `m2_i` gives `{c1_o,s2_o,s1_o,s0_o} = X*Y + K + M`. For example, X=2, Y=3, K=1 and M=2 give 9 (binary 1001).
- R4: When all operand and addend bits are one, the result is all ones over the full output width, with no overflow.
- R5: An odd width for either operand gives the same exact result as an even width. The padding bits of the internal result are always zero.
- R6: When all inputs are zero, the output is zero.
- R7: With `y_i = 0`, the output equals `k_i + m_i`, so both addends reach the result even when the product is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | X_W | Multiplicand, unsigned |
| y_i | input | Y_W | Multiplier, unsigned |
| k_i | input | X_W | Addend entering along the multiplicand edge |
| m_i | input | Y_W | Addend entering along the multiplier edge |
| sum_o | output | X_W+Y_W | Result `x_i*y_i + k_i + m_i` |

## Verification
The hardest condition to reach is the longest carry path. There, every cell of the array produces a carry at the same time, and the two addends must be absorbed along the edges without losing the top bit. The all-ones vector drives this case directly and is applied to every configuration, along with vectors where only the addends are active.

An odd-sized instance covers the padding path. A slice instance with its `M2` pin free checks the cascade pins one by one, so that an error masked by the standalone loopback still shows up. The 4x4 instance is swept over all of its 65536 input combinations.

// File: rtl/tma_pkg.sv
package tma_pkg;

   // Operand widths are rounded up to an even count before tiling.
   function automatic int even_up(input int w);
      return w + (w % 2);
   endfunction

   // Number of 2-bit groups for an operand width.
   function automatic int pair_count(input int w);
      return even_up(w) / 2;
   endfunction

endpackage

// File: rtl/tma_cell.sv
module tma_cell (
   input  logic x_i,
   input  logic y_i,
   input  logic k_i,
   input  logic m_i,
   output logic s_o,
   output logic c_o
);

   logic pp;

   assign pp  = x_i & y_i;
   assign s_o = pp ^ k_i ^ m_i;
   assign c_o = (pp & k_i) | (pp & m_i) | (k_i & m_i);

   // R1: gate form of the cell must match a 2-bit arithmetic add
   always_comb begin
      a_r1_cell_add: assert ({c_o, s_o} == (2'(pp) + 2'(k_i) + 2'(m_i)))
         else $error("cell add mismatch");
   end

endmodule

// File: rtl/tma_slice.sv
module tma_slice (
   input  logic [1:0] x_i,
   input  logic [1:0] y_i,
   input  logic [1:0] k_i,
   input  logic [1:0] m_i,
   input  logic       m2_i,
   output logic       s0_o,
   output logic       s1_o,
   output logic       s2_o,
   output logic       c1_o,
   output logic       c0_o
);

   // Row 0 (weights 1,2) ripples into c0_o.
   // Row 1 (weights 2,4) takes the row-0 middle sum and m2_i.
   logic r0_carry;
   logic r0_mid;
   logic r1_carry;

   tma_cell u_c00 (.x_i(x_i[0]), .y_i(y_i[0]), .k_i(k_i[0]), .m_i(m_i[0]),
                   .s_o(s0_o),   .c_o(r0_carry));
   tma_cell u_c10 (.x_i(x_i[1]), .y_i(y_i[0]), .k_i(k_i[1]), .m_i(r0_carry),
                   .s_o(r0_mid), .c_o(c0_o));
   tma_cell u_c01 (.x_i(x_i[0]), .y_i(y_i[1]), .k_i(r0_mid), .m_i(m_i[1]),
                   .s_o(s1_o),   .c_o(r1_carry));
   tma_cell u_c11 (.x_i(x_i[1]), .y_i(y_i[1]), .k_i(m2_i),   .m_i(r1_carry),
                   .s_o(s2_o),   .c_o(c1_o));

   // R2: weighted balance between slice pins
   always_comb begin
      a_r2_slice_balance: assert (
         (5'(x_i) * 5'(y_i) + 5'(k_i) + 5'(m_i[0]) + 5'({m_i[1], 1'b0}) + 5'({m2_i, 2'b00}))
         == (5'(s0_o) + 5'({s1_o, 1'b0}) + 5'({s2_o, 2'b00}) + 5'({c1_o, 3'b000}) + 5'({c0_o, 2'b00})))
         else $error("slice balance mismatch");
   end

endmodule

// File: rtl/tile_mul_add.sv
module tile_mul_add
   import tma_pkg::*;
#(
   parameter int X_W = 8,
   parameter int Y_W = 6
) (
   input  logic [X_W-1:0]     x_i,
   input  logic [Y_W-1:0]     y_i,
   input  logic [X_W-1:0]     k_i,
   input  logic [Y_W-1:0]     m_i,
   output logic [X_W+Y_W-1:0] sum_o
);

   localparam int XP = even_up(X_W);
   localparam int YP = even_up(Y_W);
   localparam int NX = pair_count(X_W);
   localparam int NY = pair_count(Y_W);
   localparam int SW = X_W + Y_W;
   localparam int RW = XP + YP;

   if (X_W < 1 || Y_W < 1) begin : g_bad_width
      $error("tile_mul_add: operand widths must be at least 1");
   end
   if (RW > 64) begin : g_bad_total
      $error("tile_mul_add: result wider than 64 bits is not supported");
   end

   logic [XP-1:0] x_pad, k_pad;
   logic [YP-1:0] y_pad, m_pad;
   logic [RW-1:0] raw;

   assign x_pad = XP'(x_i);
   assign k_pad = XP'(k_i);
   assign y_pad = YP'(y_i);
   assign m_pad = YP'(m_i);

   for (genvar a = 0; a < NX; a++) begin : g_x
      for (genvar b = 0; b < NY; b++) begin : g_y
         logic       s0, s1, s2, c1, c0;
         logic [1:0] kk;
         logic [1:0] mm;
         logic       m2;

         // Vertical cascade: external k on the top row.
         if (b == 0) begin : g_k_edge
            assign kk = k_pad[2*a +: 2];
         end else if (a == NX-1) begin : g_k_right
            assign kk = {g_x[a].g_y[b-1].c1, g_x[a].g_y[b-1].s2};
         end else begin : g_k_mid
            assign kk = {g_x[a+1].g_y[b-1].s1, g_x[a].g_y[b-1].s2};
         end

         // Horizontal cascade: external m on the left column.
         if (a == 0) begin : g_m_edge
            assign mm = m_pad[2*b +: 2];
         end else begin : g_m_mid
            assign mm = {g_x[a-1].g_y[b].c1, g_x[a-1].g_y[b].c0};
         end

         // Third m pin: own row carry on the right edge, else neighbour sum.
         if (a == NX-1) begin : g_m2_loop
            assign m2 = c0;
         end else begin : g_m2_mid
            assign m2 = g_x[a+1].g_y[b].s0;
         end

         tma_slice u_slice (
            .x_i (x_pad[2*a +: 2]),
            .y_i (y_pad[2*b +: 2]),
            .k_i (kk),
            .m_i (mm),
            .m2_i(m2),
            .s0_o(s0),
            .s1_o(s1),
            .s2_o(s2),
            .c1_o(c1),
            .c0_o(c0)
         );
      end
   end

   // Low result bits leave the left column.
   for (genvar b = 0; b < NY; b++) begin : g_out_lo
      assign raw[2*b]   = g_x[0].g_y[b].s0;
      assign raw[2*b+1] = g_x[0].g_y[b].s1;
   end

   // High result bits leave the bottom row.
   for (genvar a = 0; a < NX; a++) begin : g_out_hi
      assign raw[YP+2*a] = g_x[a].g_y[NY-1].s2;
      if (a > 0) begin : g_odd
         assign raw[YP-1+2*a] = g_x[a].g_y[NY-1].s1;
      end
   end
   assign raw[RW-1] = g_x[NX-1].g_y[NY-1].c1;

   assign sum_o = raw[SW-1:0];

   // R1: result against a behavioural multiply-add
   always_comb begin
      a_r1_sum_ref: assert (sum_o == (SW'(x_i) * SW'(y_i) + SW'(k_i) + SW'(m_i)))
         else $error("array result mismatch");
   end

   // R5: padded result bits must stay clear
   if (RW > SW) begin : g_pad_chk
      always_comb begin
         a_r5_pad_clear: assert (raw[RW-1:SW] == '0)
            else $error("padding bits set");
      end
   end

endmodule

// File: tb/tile_mul_add_bench.sv
`timescale 1ns/1ps
module tile_mul_add_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;   // 50 MHz

   // Default configuration 8x6
   logic [7:0]  bx, bk;
   logic [5:0]  by, bm;
   logic [13:0] bsum;
   tile_mul_add u_tile_mul_add (.x_i(bx), .y_i(by), .k_i(bk), .m_i(bm), .sum_o(bsum));

   // 4x4, swept fully
   logic [3:0] qx, qy, qk, qm;
   logic [7:0] qsum;
   tile_mul_add #(.X_W(4), .Y_W(4)) u_sq4 (.x_i(qx), .y_i(qy), .k_i(qk), .m_i(qm), .sum_o(qsum));

   // 3x5, odd widths
   logic [2:0] ox, ok;
   logic [4:0] oy, om;
   logic [7:0] osum;
   tile_mul_add #(.X_W(3), .Y_W(5)) u_odd (.x_i(ox), .y_i(oy), .k_i(ok), .m_i(om), .sum_o(osum));

   // Standalone slice with loopback
   logic [1:0] lx, ly, lk, lm;
   logic       l_s0, l_s1, l_s2, l_c1, l_c0;
   tma_slice u_loop (.x_i(lx), .y_i(ly), .k_i(lk), .m_i(lm), .m2_i(l_c0),
                     .s0_o(l_s0), .s1_o(l_s1), .s2_o(l_s2), .c1_o(l_c1), .c0_o(l_c0));

   // Slice with a free third m pin
   logic [1:0] fx, fy, fk, fm;
   logic       fm2, f_s0, f_s1, f_s2, f_c1, f_c0;
   tma_slice u_free (.x_i(fx), .y_i(fy), .k_i(fk), .m_i(fm), .m2_i(fm2),
                     .s0_o(f_s0), .s1_o(f_s1), .s2_o(f_s2), .c1_o(f_c1), .c0_o(f_c0));

   typedef struct {
      int          dut;
      longint      exp;
      string       req;
   } item_t;

   item_t q[$];
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Driver tasks: apply just after the rising edge, queue the expectation
   task automatic drv_big(input longint x, y, k, m, input string req);
      @(posedge clk); #1;
      bx = 8'(x); by = 6'(y); bk = 8'(k); bm = 6'(m);
      q.push_back('{0, x*y + k + m, req});
   endtask

   task automatic drv_sq(input longint x, y, k, m, input string req);
      @(posedge clk); #1;
      qx = 4'(x); qy = 4'(y); qk = 4'(k); qm = 4'(m);
      q.push_back('{1, x*y + k + m, req});
   endtask

   task automatic drv_odd(input longint x, y, k, m, input string req);
      @(posedge clk); #1;
      ox = 3'(x); oy = 5'(y); ok = 3'(k); om = 5'(m);
      q.push_back('{2, x*y + k + m, req});
   endtask

   task automatic drv_loop(input longint x, y, k, m, input string req);
      @(posedge clk); #1;
      lx = 2'(x); ly = 2'(y); lk = 2'(k); lm = 2'(m);
      q.push_back('{3, x*y + k + m, req});
   endtask

   task automatic drv_free(input longint x, y, k, m, m2, input string req);
      @(posedge clk); #1;
      fx = 2'(x); fy = 2'(y); fk = 2'(k); fm = 2'(m); fm2 = 1'(m2);
      q.push_back('{4, x*y + k + (m & 1) + 2*((m >> 1) & 1) + 4*m2, req});
   endtask

   // Monitor: compares on the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t  it;
         longint act;
         it = q.pop_front();
         case (it.dut)
            0:       act = longint'(bsum);
            1:       act = longint'(qsum);
            2:       act = longint'(osum);
            3:       act = longint'({l_c1, l_s2, l_s1, l_s0});
            default: act = longint'(f_s0) + 2*longint'(f_s1) + 4*longint'(f_s2)
                           + 8*longint'(f_c1) + 4*longint'(f_c0);
         endcase
         n_checks++;
         if (act != it.exp) begin
            n_fail++;
            $display("FAIL %s dut=%0d actual=%0d expected=%0d", it.req, it.dut, act, it.exp);
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      bx = '0; by = '0; bk = '0; bm = '0;
      qx = '0; qy = '0; qk = '0; qm = '0;
      ox = '0; oy = '0; ok = '0; om = '0;
      lx = '0; ly = '0; lk = '0; lm = '0;
      fx = '0; fy = '0; fk = '0; fm = '0; fm2 = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R6: all-zero inputs give zero
      drv_big(0, 0, 0, 0, "R6");
      drv_sq (0, 0, 0, 0, "R6");
      drv_odd(0, 0, 0, 0, "R6");

      // R3: worked example, then the whole standalone slice space
      drv_loop(2, 3, 1, 2, "R3");
      for (int v = 0; v < 256; v++)
         drv_loop(v & 3, (v >> 2) & 3, (v >> 4) & 3, (v >> 6) & 3, "R3");

      // R2: slice pins with a free third m input
      for (int v = 0; v < 512; v++)
         drv_free(v & 3, (v >> 2) & 3, (v >> 4) & 3, (v >> 6) & 3, (v >> 8) & 1, "R2");

      // R4: all ones on every configuration
      drv_big(255, 63, 255, 63, "R4");
      drv_sq (15, 15, 15, 15, "R4");
      drv_odd(7, 31, 7, 31, "R4");

      // R7: empty product, addends only
      drv_big(255, 0, 255, 63, "R7");
      drv_big(170, 0, 85, 42, "R7");
      drv_big(0, 0, 1, 0, "R7");

      // R5: odd widths, every x and y with random addends
      for (int v = 0; v < 256; v++)
         drv_odd(v & 7, (v >> 3) & 31, $urandom_range(7), $urandom_range(31), "R5");

      // R1: 4x4 swept exhaustively
      for (int v = 0; v < 65536; v++)
         drv_sq(v & 15, (v >> 4) & 15, (v >> 8) & 15, (v >> 12) & 15, "R1");

      // R1: random vectors on the 8x6 array
      for (int i = 0; i < 3000; i++)
         drv_big($urandom_range(255), $urandom_range(63), $urandom_range(255),
                 $urandom_range(63), "R1");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule